// File: doc/BRIEF.md
# Reservation Monitor for Atomic Read-Modify-Write

This block sits in front of a small word-addressed memory that several harts share. It lets them build atomic sequences from two operations. A load-reserved returns a word and starts watching that address on behalf of the caller. A later store-conditional from the same hart writes only if nothing else has written the watched word in between. It reports its outcome as a status word, and software repeats the whole sequence whenever that status reports failure. The block also serves plain reads and plain writes.

Every hart has its own request port, with a valid bit, an operation code, an address and write data. When several harts request in the same cycle, a fixed-priority arbiter accepts one of them per cycle. A hart keeps its request asserted until it sees its ready bit high. One cycle after acceptance, that hart's response-valid bit pulses. A single shared data bus then carries either the word that was read or the status code.

Each hart can hold one reservation. The reservation is an address and a valid flag, and it is cleared on reset. Any write that the memory actually performs kills the reservations that other harts hold on that word. No intermediate clearing step is needed between retries.

Top module: `resv_monitor_top`

## Requirements
- R1: While reset is high and on the first cycle after it, no ready or response is given. Reset clears every reservation, so a store-conditional issued straight after reset returns 1 and does not write.
- R2: The hart h operation code sits in req_op[2h+1:2h]: 0 is read, 1 is write, 2 is load-reserved and 3 is store-conditional. A read returns the stored word. A write stores its data and returns 0.
- R3: A load-reserved returns the stored word and records a reservation for the requesting hart on that address.
- R4: A store-conditional whose hart holds a valid reservation on the same address writes its data and returns 0.
- R5: If another hart writes the reserved word after the load-reserved, the store-conditional returns 1 and leaves memory unchanged.
- R6: A store-conditional to an address other than the reserved one returns 1 and does not write.
- R7: Every store-conditional clears the issuing hart's reservation, whether it succeeds or fails. A repeated store-conditional therefore fails.
- R8: A new load-reserved replaces the hart's earlier reservation.
- R9: At most one request is accepted per cycle. The accepted one is the valid request with the lowest hart index.
- R10: Of two store-conditionals to the same reserved word that arrive together, only the one accepted first succeeds.
- R11: Exactly the accepted hart sees its response-valid bit high in the next cycle, and on no other cycle.
- R12: A hart's plain write to its own reserved word does not break its own reservation. A write to a different word breaks no reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N | Request present, one bit per hart |
| req_op | input | 2*N | Operation code per hart, 2 bits each |
| req_addr | input | AW*N | Word address per hart |
| req_wdata | input | DW*N | Write data per hart |
| req_ready | output | N | One-hot acceptance of this cycle's request |
| rsp_valid | output | N | Response pulse, one cycle after acceptance |
| rsp_data | output | DW | Read word, or status (0 = done/success, 1 = failed) |

## Verification
The stimulus begins with single-hart reservation pairs that succeed. These are followed by sequences in which another hart's write lands between the reservation and the conditional store, and by sequences in which the conditional store names a different address. Comparing these cases separates a monitor that tracks writes per address from one that only counts time or only remembers the hart. Repeated conditional stores and back-to-back load-reserved operations show whether a hart's single reservation is cleared or replaced correctly. Simultaneous requests from all harts, including two conditional stores racing for one word, expose the arbitration order and show whether the first accepted write invalidates the second in time.

// File: rtl/resv_pkg.sv
package resv_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_LRES  = 2'd2,
    OP_SCOND = 2'd3
  } resv_op_e;

  localparam logic ST_PASS = 1'b0;
  localparam logic ST_FAIL = 1'b1;
endpackage

// File: rtl/resv_prio_arb.sv
module resv_prio_arb #(
  parameter int N = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);
  // Lowest index wins: scan from the top so the last hit is the lowest.
  always_comb begin
    gnt = '0;
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
        idx    = IW'(i);
        any    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/resv_table.sv
module resv_table
  import resv_pkg::*;
#(
  parameter int N  = 4,
  parameter int AW = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [IW-1:0] idx,
  input  resv_op_e      op,
  input  logic [AW-1:0] addr,
  output logic          sc_ok
);
  logic [N-1:0]  vld_vec;
  logic [AW-1:0] adr_arr [N];

  assign sc_ok = vld_vec[idx] && (adr_arr[idx] == addr);

  for (genvar g = 0; g < N; g++) begin : g_entry
    logic          v_q;
    logic [AW-1:0] a_q;
    logic          self_h;
    logic          hit;

    assign self_h     = (idx == IW'(g));
    assign hit        = v_q && (a_q == addr);
    assign vld_vec[g] = v_q;
    assign adr_arr[g] = a_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        v_q <= 1'b0;
        a_q <= '0;
      end else if (en) begin
        unique case (op)
          OP_LRES: begin
            if (self_h) begin
              v_q <= 1'b1;
              a_q <= addr;
            end
          end
          OP_SCOND: begin
            if (self_h) v_q <= 1'b0;
            else if (sc_ok && hit) v_q <= 1'b0;
          end
          OP_WRITE: begin
            if (!self_h && hit) v_q <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/resv_word_mem.sv
module resv_word_mem #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  // Single port, read-before-write, registered read: block RAM friendly.
  always_ff @(posedge clk) begin
    if (we) mem_q[addr] <= wdata;
    rdata <= mem_q[addr];
  end
endmodule

// File: rtl/resv_monitor_top.sv
module resv_monitor_top
  import resv_pkg::*;
#(
  parameter int N  = 4,
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    req_valid,
  input  logic [2*N-1:0]  req_op,
  input  logic [AW*N-1:0] req_addr,
  input  logic [DW*N-1:0] req_wdata,
  output logic [N-1:0]    req_ready,
  output logic [N-1:0]    rsp_valid,
  output logic [DW-1:0]   rsp_data
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  resv_op_e      op_arr   [N];
  logic [AW-1:0] addr_arr [N];
  logic [DW-1:0] data_arr [N];

  for (genvar g = 0; g < N; g++) begin : g_unpack
    assign op_arr[g]   = resv_op_e'(req_op[2*g +: 2]);
    assign addr_arr[g] = req_addr[AW*g +: AW];
    assign data_arr[g] = req_wdata[DW*g +: DW];
  end

  logic [N-1:0]  gnt;
  logic [IW-1:0] gidx;
  logic          gany;

  resv_prio_arb #(.N(N), .IW(IW)) u_arb (
    .req (req_valid & {N{~rst}}),
    .gnt (gnt),
    .idx (gidx),
    .any (gany)
  );

  assign req_ready = gnt;

  resv_op_e      g_op;
  logic [AW-1:0] g_addr;
  logic [DW-1:0] g_data;
  logic          sc_ok;
  logic          mem_we;
  logic [DW-1:0] mem_rdata;

  assign g_op   = op_arr[gidx];
  assign g_addr = addr_arr[gidx];
  assign g_data = data_arr[gidx];

  resv_table #(.N(N), .AW(AW), .IW(IW)) u_tbl (
    .clk   (clk),
    .rst   (rst),
    .en    (gany),
    .idx   (gidx),
    .op    (g_op),
    .addr  (g_addr),
    .sc_ok (sc_ok)
  );

  assign mem_we = gany && ((g_op == OP_WRITE) || ((g_op == OP_SCOND) && sc_ok));

  resv_word_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .addr  (g_addr),
    .wdata (g_data),
    .rdata (mem_rdata)
  );

  logic [N-1:0] rsp_valid_q;
  logic         is_status_q;
  logic         status_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_q <= '0;
      is_status_q <= 1'b0;
      status_q    <= ST_PASS;
    end else begin
      rsp_valid_q <= gnt;
      is_status_q <= (g_op == OP_WRITE) || (g_op == OP_SCOND);
      status_q    <= ((g_op == OP_SCOND) && !sc_ok) ? ST_FAIL : ST_PASS;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = is_status_q ? {{(DW-1){1'b0}}, status_q} : mem_rdata;
endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk #(
  parameter int N  = 4,
  parameter int AW = 4,
  parameter int DW = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [N-1:0]    req_valid,
  input logic [2*N-1:0]  req_op,
  input logic [N-1:0]    req_ready,
  input logic [N-1:0]    rsp_valid,
  input logic [DW-1:0]   rsp_data
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (rsp_valid == '0));

  assert_ready_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req_ready));

  assert_ready_needs_req_R9: assert property (@(posedge clk) disable iff (rst)
    ((req_ready & ~req_valid) == '0));

  assert_rsp_after_grant_R11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rsp_valid == $past(req_ready)));

  for (genvar g = 0; g < N; g++) begin : g_h
    assert_sc_code_R4: assert property (@(posedge clk) disable iff (rst)
      (req_ready[g] && (req_op[2*g +: 2] == 2'd3)) |=> (rsp_valid[g] && (rsp_data <= DW'(1))));
  end

  for (genvar g = 1; g < N; g++) begin : g_p
    assert_lowest_wins_R9: assert property (@(posedge clk) disable iff (rst)
      req_ready[g] |-> (req_valid[g-1:0] == '0));
  end
endmodule

bind resv_monitor_top resv_monitor_chk #(.N(N), .AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_op    (req_op),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data)
);

// File: tb/resv_monitor_top_tb_top.sv
module resv_monitor_top_tb_top;
  import resv_pkg::*;

  localparam int NH = 4;
  localparam int AW = 4;
  localparam int DW = 32;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NH-1:0]    req_valid = '0;
  logic [2*NH-1:0]  req_op = '0;
  logic [AW*NH-1:0] req_addr = '0;
  logic [DW*NH-1:0] req_wdata = '0;
  logic [NH-1:0]    req_ready;
  logic [NH-1:0]    rsp_valid;
  logic [DW-1:0]    rsp_data;

  always #5 clk = ~clk;

  resv_monitor_top #(.N(NH), .AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_tag = "R1";

  // pending request per hart
  bit          p_valid [NH];
  resv_op_e    p_op    [NH];
  int          p_addr  [NH];
  logic [31:0] p_data  [NH];

  // behavioural reference
  logic [31:0] m_mem [1 << AW];
  bit          m_rv  [NH];
  int          m_ra  [NH];

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (%s) actual=%0h expected=%0h", tag, cur_tag, act, exp);
    end
  endtask

  task automatic issue(int h, resv_op_e op, int a, logic [31:0] d);
    p_valid[h] = 1'b1;
    p_op[h]    = op;
    p_addr[h]  = a;
    p_data[h]  = d;
  endtask

  task automatic step();
    int g;
    logic [NH-1:0] eg;
    logic [31:0] ed;
    string dtag;
    for (int h = 0; h < NH; h++) begin
      req_valid[h]         = p_valid[h];
      req_op[2*h +: 2]     = p_op[h];
      req_addr[AW*h +: AW] = AW'(p_addr[h]);
      req_wdata[DW*h +: DW] = p_data[h];
    end
    #1;
    g = -1;
    for (int h = 0; h < NH; h++) if (p_valid[h] && g < 0) g = h;
    eg = (g >= 0) ? NH'(1 << g) : '0;
    chk(req_ready == eg, "R9", 32'(req_ready), 32'(eg));
    ed = '0;
    dtag = "R2";
    if (g >= 0) begin
      int a;
      a = p_addr[g];
      case (p_op[g])
        OP_READ:  begin ed = m_mem[a]; dtag = "R2"; end
        OP_WRITE: begin
          m_mem[a] = p_data[g]; ed = 0; dtag = "R2";
          for (int j = 0; j < NH; j++) if (j != g && m_rv[j] && m_ra[j] == a) m_rv[j] = 1'b0;
        end
        OP_LRES:  begin ed = m_mem[a]; m_rv[g] = 1'b1; m_ra[g] = a; dtag = "R3"; end
        default: begin
          bit ok;
          ok = m_rv[g] && (m_ra[g] == a);
          m_rv[g] = 1'b0;
          if (ok) begin
            m_mem[a] = p_data[g];
            for (int j = 0; j < NH; j++) if (j != g && m_rv[j] && m_ra[j] == a) m_rv[j] = 1'b0;
          end
          ed = ok ? 32'd0 : 32'd1;
          dtag = ok ? "R4" : "R5";
        end
      endcase
    end
    @(negedge clk);
    chk(rsp_valid == eg, "R11", 32'(rsp_valid), 32'(eg));
    if (g >= 0) begin
      chk(rsp_data == ed, dtag, rsp_data, ed);
      p_valid[g] = 1'b0;
    end
  endtask

  task automatic drain();
    bit busy;
    busy = 1'b1;
    while (busy) begin
      step();
      busy = 1'b0;
      for (int h = 0; h < NH; h++) if (p_valid[h]) busy = 1'b1;
    end
  endtask

  task automatic one(int h, resv_op_e op, int a, logic [31:0] d);
    issue(h, op, a, d);
    drain();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int h = 0; h < NH; h++) begin
      p_valid[h] = 1'b0; p_op[h] = OP_READ; p_addr[h] = 0; p_data[h] = '0;
      m_rv[h] = 1'b0; m_ra[h] = 0;
    end
    repeat (3) @(posedge clk);
    // R1: outputs idle while in reset
    #1;
    chk(req_ready == '0, "R1", 32'(req_ready), 0);
    chk(rsp_valid == '0, "R1", 32'(rsp_valid), 0);
    @(negedge clk);
    rst = 1'b0;
    // R1: idle cycle, then a conditional store with no reservation fails
    cur_tag = "R1";
    step();
    one(0, OP_SCOND, 0, 32'hDEAD0000);

    // R2: fill memory from rotating harts, read back
    cur_tag = "R2";
    for (int a = 0; a < (1 << AW); a++) one(a % NH, OP_WRITE, a, 32'h1000 + a);
    for (int a = 0; a < (1 << AW); a += 3) one((a + 1) % NH, OP_READ, a, 0);

    // R3 R4: clean pair succeeds and lands in memory
    cur_tag = "R4";
    one(1, OP_LRES, 5, 0);
    one(1, OP_SCOND, 5, 32'hA5A5_0005);
    one(2, OP_READ, 5, 0);

    // R5: intervening write from another hart kills the reservation
    cur_tag = "R5";
    one(0, OP_LRES, 3, 0);
    one(2, OP_WRITE, 3, 32'hBEEF_0003);
    one(0, OP_SCOND, 3, 32'h0BAD_0003);
    one(0, OP_READ, 3, 0);

    // R6 R7: wrong address fails without writing, and the retry also fails
    cur_tag = "R6";
    one(2, OP_LRES, 7, 0);
    one(2, OP_SCOND, 8, 32'h0BAD_0008);
    one(3, OP_READ, 8, 0);
    cur_tag = "R7";
    one(2, OP_SCOND, 7, 32'h0BAD_0007);
    one(3, OP_READ, 7, 0);

    // R7: success clears own reservation, second store-conditional fails
    one(3, OP_LRES, 9, 0);
    one(3, OP_SCOND, 9, 32'h0000_9999);
    one(3, OP_SCOND, 9, 32'h0BAD_0009);
    one(0, OP_READ, 9, 0);

    // R8: newer reservation replaces older
    cur_tag = "R8";
    one(1, OP_LRES, 2, 0);
    one(1, OP_LRES, 4, 0);
    one(1, OP_SCOND, 4, 32'h0000_4444);
    one(1, OP_LRES, 2, 0);
    one(1, OP_LRES, 4, 0);
    one(1, OP_SCOND, 2, 32'h0BAD_0002);
    one(1, OP_READ, 2, 0);

    // R10 R9: racing conditional stores, hart 0 wins, hart 3 fails
    cur_tag = "R10";
    one(0, OP_LRES, 6, 0);
    one(3, OP_LRES, 6, 0);
    issue(3, OP_SCOND, 6, 32'h3333_0006);
    issue(0, OP_SCOND, 6, 32'h0000_0006);
    drain();
    one(2, OP_READ, 6, 0);

    // R9 R11: all harts at once, served lowest index first
    cur_tag = "R9";
    for (int h = 0; h < NH; h++) issue(h, OP_READ, 10 + h, 0);
    drain();
    for (int h = NH - 1; h >= 0; h--) issue(h, OP_WRITE, h, 32'h7700 + h);
    drain();

    // R12: own write keeps own reservation, write elsewhere breaks nothing
    cur_tag = "R12";
    one(2, OP_LRES, 10, 0);
    one(2, OP_WRITE, 10, 32'h0000_AAAA);
    one(2, OP_SCOND, 10, 32'h0000_BBBB);
    one(1, OP_LRES, 11, 0);
    one(0, OP_WRITE, 12, 32'h0000_CCCC);
    one(1, OP_SCOND, 11, 32'h0000_DDDD);
    one(3, OP_READ, 10, 0);
    one(3, OP_READ, 11, 0);

    // R1: a fresh reset drops every reservation
    cur_tag = "R1";
    one(0, OP_LRES, 1, 0);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int h = 0; h < NH; h++) m_rv[h] = 1'b0;
    step();
    one(0, OP_SCOND, 1, 32'h0BAD_0001);
    one(0, OP_READ, 1, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule